// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block sits between a shared bidirectional bus and local logic. A narrow transmit register collects the bitwise OR of two local data words and drives it onto the bus through a tri-state driver. A receive register of the same width captures the bus lines and presents them on the local outputs. Each register has its own load control, and holds its contents when that control is low. The data path does not invert in either direction.

The bus driver is controlled by an enable flip-flop. A synchronous enable input is sampled on each rising clock edge. An asynchronous disable input turns the driver off at once, without a clock edge. An active-low override sets the flip-flop at once. With the override held low, the driver comes back as soon as the disable is released. With the override high, the driver comes back only after a clock edge samples the synchronous enable high.

For test, a scan input links both registers into one serial chain. In this mode the chain moves one place on every clock. The serial output is the top bit of the receive outputs. The bus pin is modelled as three signals: bus-in, bus-out and output-enable. The data interface carries one word per clock with no valid/ready handshake, so back-pressure does not apply. All pins are plain levels.

Top module: `scan_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both registers and the enable flip-flop clear to zero, so `q_out`, `bus_out` and `bus_oe` are 0.
- R2: With `scan_mode` low and `tx_load` high, a rising edge loads the transmit register with `a_in | b_in`. The value appears unchanged on `bus_out` when `bus_oe` is 1.
- R3: With `scan_mode` low and `tx_load` low, the transmit register keeps its value across a clock edge, even when `a_in` and `b_in` change.
- R4: With `scan_mode` low and `rx_load` high, a rising edge loads `bus_in` into the receive register. The value appears unchanged on `q_out`.
- R5: With `scan_mode` low and `rx_load` low, `q_out` keeps its value across a clock edge, even when `bus_in` changes.
- R6: `bus_out` is all zeros whenever `bus_oe` is 0, and `bus_oe` is 1 only when the enable flip-flop is set and `bus_dis_async` is low.
- R7: Raising `bus_dis_async` forces `bus_oe` to 0 and `bus_out` to 0 at once, with no clock edge.
- R8: With `sync_ovr_n` high, the enable flip-flop takes the value of `bus_en_sync` on each rising edge. After `bus_dis_async` falls, the driver stays off until an edge samples `bus_en_sync` high.
- R9: A low level on `sync_ovr_n` sets the enable flip-flop at once and holds it set through clock edges. If `bus_dis_async` is also high, the disable wins and `bus_oe` stays 0. When `bus_dis_async` then falls, `bus_oe` becomes 1 without a clock edge.
- R10: With `scan_mode` high, each rising edge shifts the chain one place. The order is `scan_in` into transmit bit 0, then transmit bit 0 to 1 to 2, then transmit bit 2 into receive bit 0, then receive bit 0 to 1 to 2. After six shifts of bits s0..s5 (s0 first), the transmit register holds {s3,s4,s5} and the receive register holds {s0,s1,s2}, each listed bit 2 down to bit 0.
- R11: `q_out[2]` serves as the scan output: after six shifts it carries the first bit that was shifted in.
- R12: In scan mode, `tx_load`, `rx_load`, `a_in`, `b_in` and `bus_in` have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 3 | First transmit data word |
| b_in | input | 3 | Second transmit data word, ORed with `a_in` |
| tx_load | input | 1 | Transmit register load (1) or hold (0) |
| rx_load | input | 1 | Receive register load (1) or hold (0) |
| scan_mode | input | 1 | 1 selects serial scan shifting |
| scan_in | input | 1 | Serial scan data input |
| bus_dis_async | input | 1 | Asynchronous bus driver disable, active high |
| bus_en_sync | input | 1 | Synchronous enable sampled into the enable flip-flop |
| sync_ovr_n | input | 1 | Active-low asynchronous set of the enable flip-flop |
| bus_in | input | 3 | Values read from the bus lines |
| bus_out | output | 3 | Data driven onto the bus; zero when not enabled |
| bus_oe | output | 1 | Bus driver output enable |
| q_out | output | 3 | Receive register outputs; bit 2 is the scan output |

## Verification
Two situations are the hardest to reach from the ports. The first is the gap between the release of the asynchronous disable and the next clock edge. The bench reaches it by changing `bus_dis_async` and `sync_ovr_n` between clock edges and checking `bus_oe` before any edge arrives. This is how it tells an override-driven re-enable from a clocked one, and shows that the disable wins when both are active. The second is the state of the scan chain, which cannot be seen directly. The bench shifts every 6-bit pattern through the chain, then leaves scan mode with both loads low. It reads the transmit half on `bus_out` and the receive half on `q_out`. For half of the patterns it holds the load controls and data inputs active during the shifts, to show that they have no effect.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 3;

  function automatic logic [XCVR_W-1:0] merge_words(input logic [XCVR_W-1:0] x,
                                                    input logic [XCVR_W-1:0] y);
    return x | y;
  endfunction
endpackage

// File: rtl/xcvr_chain_reg.sv
module xcvr_chain_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         load,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_bit;
    if (i == 0) begin : g_head
      assign prev_bit = ser_in;
    end else begin : g_body
      assign prev_bit = q[i-1];
    end
    always_comb begin
      if (shift)     nxt[i] = prev_bit;
      else if (load) nxt[i] = par_in[i];
      else           nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/xcvr_oe_ff.sv
module xcvr_oe_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n or negedge set_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (!set_n) q <= 1'b1;
    else             q <= d;
  end
endmodule

// File: rtl/scan_bus_xcvr.sv
module scan_bus_xcvr #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         tx_load,
  input  logic         rx_load,
  input  logic         scan_mode,
  input  logic         scan_in,
  input  logic         bus_dis_async,
  input  logic         bus_en_sync,
  input  logic         sync_ovr_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] q_out
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;
  logic [W-1:0] tx_word;
  logic         en_q;

  assign tx_word = xcvr_pkg::merge_words(a_in, b_in);

  xcvr_chain_reg #(.W(W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (scan_mode),
    .load  (tx_load),
    .ser_in(scan_in),
    .par_in(tx_word),
    .q     (tx_q)
  );

  xcvr_chain_reg #(.W(W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (scan_mode),
    .load  (rx_load),
    .ser_in(tx_q[W-1]),
    .par_in(bus_in),
    .q     (rx_q)
  );

  xcvr_oe_ff u_oe (
    .clk  (clk),
    .rst_n(rst_n),
    .set_n(sync_ovr_n),
    .d    (bus_en_sync),
    .q    (en_q)
  );

  assign bus_oe  = en_q & ~bus_dis_async;
  assign bus_out = bus_oe ? tx_q : '0;
  assign q_out   = rx_q;
endmodule

// File: rtl/scan_bus_xcvr_chk.sv
module scan_bus_xcvr_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         tx_load,
  input logic         rx_load,
  input logic         scan_mode,
  input logic         scan_in,
  input logic         bus_dis_async,
  input logic         bus_en_sync,
  input logic         sync_ovr_n,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [W-1:0] q_out,
  input logic [W-1:0] tx_q
);
  a_r2_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && tx_load) |=> tx_q == ($past(a_in) | $past(b_in)));

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && !tx_load) |=> $stable(tx_q));

  a_r4_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && rx_load) |=> q_out == $past(bus_in));

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && !rx_load) |=> $stable(q_out));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);

  a_r6_drive_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_out == tx_q);

  a_r7_async_off: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dis_async |-> !bus_oe);

  a_r8_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ovr_n ##1 (sync_ovr_n && !bus_dis_async) |-> bus_oe == $past(bus_en_sync));

  a_r9_override_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ovr_n && !bus_dis_async) |-> bus_oe);

  a_r10_tx_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> tx_q == {$past(tx_q[W-2:0]), $past(scan_in)});

  a_r11_rx_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> q_out == {$past(q_out[W-2:0]), $past(tx_q[W-1])});
endmodule

bind scan_bus_xcvr scan_bus_xcvr_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .a_in         (a_in),
  .b_in         (b_in),
  .tx_load      (tx_load),
  .rx_load      (rx_load),
  .scan_mode    (scan_mode),
  .scan_in      (scan_in),
  .bus_dis_async(bus_dis_async),
  .bus_en_sync  (bus_en_sync),
  .sync_ovr_n   (sync_ovr_n),
  .bus_in       (bus_in),
  .bus_out      (bus_out),
  .bus_oe       (bus_oe),
  .q_out        (q_out),
  .tx_q         (tx_q)
);

// File: tb/sim_scan_bus_xcvr.sv
`timescale 1ns/1ps
module sim_scan_bus_xcvr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] a_in, b_in, bus_in;
  logic       tx_load, rx_load, scan_mode, scan_in;
  logic       bus_dis_async, bus_en_sync, sync_ovr_n;
  logic [2:0] bus_out, q_out;
  logic       bus_oe;
  int         n_run = 0;
  int         n_fail = 0;
  logic [2:0] prev;
  logic [2:0] tx_exp, rx_exp;

  always #10 clk = ~clk;

  scan_bus_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .tx_load(tx_load), .rx_load(rx_load), .scan_mode(scan_mode),
    .scan_in(scan_in), .bus_dis_async(bus_dis_async),
    .bus_en_sync(bus_en_sync), .sync_ovr_n(sync_ovr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .q_out(q_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; a_in = 0; b_in = 0; bus_in = 0; tx_load = 0; rx_load = 0;
    scan_mode = 0; scan_in = 0; bus_dis_async = 0; bus_en_sync = 0; sync_ovr_n = 1;
    tick(); tick();
    chk("R1 q_out", q_out, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 bus_out", bus_out, 0);
    rst_n = 1;

    bus_en_sync = 1;
    tick();
    chk("R8 clocked enable", bus_oe, 1);

    tx_load = 1;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        a_in = a[2:0]; b_in = b[2:0];
        tick();
        chk("R2 tx load", bus_out, a | b);
      end
    end

    tx_load = 0;
    for (int k = 0; k < 8; k++) begin
      prev = bus_out;
      a_in = k[2:0]; b_in = ~k[2:0];
      tick();
      chk("R3 tx hold", bus_out, prev);
    end

    rx_load = 1;
    for (int v = 0; v < 8; v++) begin
      bus_in = v[2:0];
      tick();
      chk("R4 rx load", q_out, v);
    end
    rx_load = 0;
    for (int k = 0; k < 8; k++) begin
      prev = q_out;
      bus_in = k[2:0] ^ 3'b101;
      tick();
      chk("R5 rx hold", q_out, prev);
    end

    tx_load = 1; a_in = 3'b101; b_in = 3'b000;
    tick();
    tx_load = 0;
    bus_dis_async = 1;
    #1;
    chk("R7 async oe", bus_oe, 0);
    chk("R7 async data", bus_out, 0);
    tick();
    chk("R6 disabled data", bus_out, 0);

    bus_en_sync = 0;
    tick();
    bus_dis_async = 0;
    #1;
    chk("R8 waits for edge", bus_oe, 0);
    bus_en_sync = 1;
    tick();
    chk("R8 re-enable on edge", bus_oe, 1);
    chk("R6 drive data", bus_out, 5);

    bus_en_sync = 0; bus_dis_async = 1;
    tick();
    sync_ovr_n = 0;
    #1;
    chk("R9 disable wins", bus_oe, 0);
    bus_dis_async = 0;
    #1;
    chk("R9 async re-enable", bus_oe, 1);
    tick();
    chk("R9 held through edge", bus_oe, 1);
    sync_ovr_n = 1; bus_en_sync = 1;
    tick();
    chk("R8 override released", bus_oe, 1);

    for (int p = 0; p < 64; p++) begin
      scan_mode = 1;
      tx_load = p[0]; rx_load = p[0];
      a_in = 3'b111; b_in = 3'b111; bus_in = 3'b111 ^ p[2:0];
      for (int j = 0; j < 6; j++) begin
        scan_in = p[j];
        tick();
      end
      scan_mode = 0; tx_load = 0; rx_load = 0;
      for (int i = 0; i < 3; i++) begin
        tx_exp[i] = p[5-i];
        rx_exp[i] = p[2-i];
      end
      #1;
      chk(p[0] ? "R12 tx ignores loads" : "R10 tx chain", bus_out, tx_exp);
      chk(p[0] ? "R12 rx ignores loads" : "R10 rx chain", q_out, rx_exp);
      chk("R11 scan out", q_out[2], p[0]);
      tick();
    end

    report();
  end
endmodule